// File: doc/BRIEF.md
# Composite Sync Insertion Mux

This block sits between a video timing generator and the output converters. For every sample it chooses what each of the three component channels (luma, Cb, Cr) carries. The choices are a programmed negative sync level, a programmed positive sync level, a programmed blank level, or the incoming pixel. Per-sample flags from the timing generator say which of these the sample needs. The luma channel has its own set of three levels. Both chroma channels share a second set.

An insertion mode chooses where sync is inserted: on luma only, on all three channels, or nowhere. A channel that receives no insertion shows its blank level during sync intervals. Serration and broad pulses inside vertical blanking come to this block as ordinary sync-low or sync-high flags, so they use the same programmed amplitudes. Some vertical-blanking lines carry no pulse at all. A pass-through control decides whether the active portion of those lines carries video or the blank level.

The outputs are registered. Pixel data and flags presented together appear together on the outputs one clock later.

Top module: `csync_mux`

## Requirements
- R1: While rst_ni is low, y_o, cb_o and cr_o are all zero. They clear at once when rst_ni falls, without waiting for a clock edge.
- R2: An output sample reflects the flags, levels and data that were sampled on the previous rising clock edge. The latency is exactly one cycle.
- R3: Mode encoding is 2'b00 no insertion, 2'b01 luma only, 2'b10 all channels, and 2'b11 is treated as no insertion. When sync_lo_i is high, it overrides every other flag. In that case y_o takes y_sync_lo_i under modes 01 and 10, and cb_o and cr_o take c_sync_lo_i under mode 10.
- R4: When sync_hi_i is high and sync_lo_i is low, sync_hi_i overrides blank_i and active_i. In that case y_o takes y_sync_hi_i under modes 01 and 10, and cb_o and cr_o take c_sync_hi_i under mode 10.
- R5: During a sync interval (sync_lo_i or sync_hi_i high), a channel that receives no insertion under the current mode outputs its blank level. For luma that is y_blank_i, and for chroma it is c_blank_i.
- R6: When blank_i is high and neither sync flag is high, the outputs are y_blank_i and c_blank_i, even if active_i is high.
- R7: When active_i is high, all other flags are low and vbl_quiet_i is low, y_i, cb_i and cr_i pass unchanged. This holds under every mode.
- R8: On an active sample with vbl_quiet_i high, no sync flag and no blank flag, the output depends on pass_vblank_i. When pass_vblank_i is 1 the pixel data passes. When it is 0 the blank levels are output.
- R9: A sample with none of sync_lo_i, sync_hi_i, blank_i or active_i set outputs the blank levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Insertion mode (00 none, 01 luma, 10 all, 11 none) |
| pass_vblank_i | input | 1 | Pass video on pulse-free vertical-blanking lines |
| y_sync_lo_i | input | DW | Luma negative sync level |
| y_sync_hi_i | input | DW | Luma positive sync level |
| y_blank_i | input | DW | Luma blank level |
| c_sync_lo_i | input | DW | Chroma negative sync level |
| c_sync_hi_i | input | DW | Chroma positive sync level |
| c_blank_i | input | DW | Chroma blank level |
| sync_lo_i | input | 1 | Sample lies in a negative sync pulse |
| sync_hi_i | input | 1 | Sample lies in a positive sync pulse |
| blank_i | input | 1 | Sample lies in blanking |
| active_i | input | 1 | Sample lies in the active portion of the line |
| vbl_quiet_i | input | 1 | Line is in vertical blanking and carries no pulse |
| y_i | input | DW | Luma pixel |
| cb_i | input | DW | Cb pixel |
| cr_i | input | DW | Cr pixel |
| y_o | output | DW | Luma output |
| cb_o | output | DW | Cb output |
| cr_o | output | DW | Cr output |

## Verification
Most faults in this block come from the selection logic, either a wrong mode decode or a wrong priority order. Such a fault shows on the next output sample as a level taken from the wrong register, or as pixel data where a level belongs. A swapped luma and chroma level set shows as a known constant on the wrong channel. A missing or extra pipeline stage shifts every output by one sample, which the latency check catches on the first changed input. Each vector pairs one flag pattern with one mode, so a mismatch points straight at the priority step that broke.

// File: rtl/csync_pkg.sv
package csync_pkg;
  typedef enum logic [1:0] {
    INS_NONE = 2'b00,
    INS_LUMA = 2'b01,
    INS_ALL  = 2'b10,
    INS_RSVD = 2'b11
  } ins_mode_e;

  typedef struct packed {
    logic sync_lo;
    logic sync_hi;
    logic blank;
    logic active;
    logic vbl_quiet;
  } tflags_t;

  localparam int unsigned NCH = 3;
endpackage

// File: rtl/csync_mode_dec.sv
module csync_mode_dec
  import csync_pkg::*;
(
  input  logic [1:0] mode_i,
  output logic       ins_y_o,
  output logic       ins_c_o
);
  ins_mode_e mode;
  assign mode = ins_mode_e'(mode_i);

  always_comb begin
    ins_y_o = 1'b0;
    ins_c_o = 1'b0;
    unique case (mode)
      INS_LUMA: ins_y_o = 1'b1;
      INS_ALL: begin
        ins_y_o = 1'b1;
        ins_c_o = 1'b1;
      end
      default: ;  // none and reserved: no insertion
    endcase
  end
endmodule

// File: rtl/csync_chan_sel.sv
module csync_chan_sel
  import csync_pkg::*;
#(
  parameter int unsigned DW = 10
) (
  input  tflags_t       flags_i,
  input  logic          ins_i,
  input  logic          pass_i,
  input  logic [DW-1:0] lvl_lo_i,
  input  logic [DW-1:0] lvl_hi_i,
  input  logic [DW-1:0] lvl_blank_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] val_o
);
  logic show_video;
  assign show_video = flags_i.active && (!flags_i.vbl_quiet || pass_i);

  always_comb begin
    if (flags_i.sync_lo)      val_o = ins_i ? lvl_lo_i : lvl_blank_i;
    else if (flags_i.sync_hi) val_o = ins_i ? lvl_hi_i : lvl_blank_i;
    else if (flags_i.blank)   val_o = lvl_blank_i;
    else if (show_video)      val_o = data_i;
    else                      val_o = lvl_blank_i;
  end
endmodule

// File: rtl/csync_mux.sv
module csync_mux
  import csync_pkg::*;
#(
  parameter int unsigned DW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          pass_vblank_i,
  input  logic [DW-1:0] y_sync_lo_i,
  input  logic [DW-1:0] y_sync_hi_i,
  input  logic [DW-1:0] y_blank_i,
  input  logic [DW-1:0] c_sync_lo_i,
  input  logic [DW-1:0] c_sync_hi_i,
  input  logic [DW-1:0] c_blank_i,
  input  logic          sync_lo_i,
  input  logic          sync_hi_i,
  input  logic          blank_i,
  input  logic          active_i,
  input  logic          vbl_quiet_i,
  input  logic [DW-1:0] y_i,
  input  logic [DW-1:0] cb_i,
  input  logic [DW-1:0] cr_i,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] cb_o,
  output logic [DW-1:0] cr_o
);
  tflags_t       flags;
  logic          ins_y, ins_c;
  logic [DW-1:0] data [NCH];
  logic [DW-1:0] sel  [NCH];
  logic [DW-1:0] q    [NCH];

  assign flags = '{sync_lo: sync_lo_i, sync_hi: sync_hi_i, blank: blank_i,
                   active: active_i, vbl_quiet: vbl_quiet_i};
  assign data[0] = y_i;
  assign data[1] = cb_i;
  assign data[2] = cr_i;

  csync_mode_dec u_dec (
    .mode_i  (mode_i),
    .ins_y_o (ins_y),
    .ins_c_o (ins_c)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam bit IS_LUMA = (ch == 0);
    csync_chan_sel #(.DW(DW)) u_sel (
      .flags_i     (flags),
      .ins_i       (IS_LUMA ? ins_y : ins_c),
      .pass_i      (pass_vblank_i),
      .lvl_lo_i    (IS_LUMA ? y_sync_lo_i : c_sync_lo_i),
      .lvl_hi_i    (IS_LUMA ? y_sync_hi_i : c_sync_hi_i),
      .lvl_blank_i (IS_LUMA ? y_blank_i   : c_blank_i),
      .data_i      (data[ch]),
      .val_o       (sel[ch])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[ch] <= '0;
      else         q[ch] <= sel[ch];
    end
  end

  assign y_o  = q[0];
  assign cb_o = q[1];
  assign cr_o = q[2];
endmodule

// File: rtl/csync_mux_chk.sv
module csync_mux_chk #(
  parameter int unsigned DW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    mode_i,
  input logic          pass_vblank_i,
  input logic [DW-1:0] y_sync_lo_i,
  input logic [DW-1:0] y_sync_hi_i,
  input logic [DW-1:0] y_blank_i,
  input logic [DW-1:0] c_sync_lo_i,
  input logic [DW-1:0] c_sync_hi_i,
  input logic [DW-1:0] c_blank_i,
  input logic          sync_lo_i,
  input logic          sync_hi_i,
  input logic          blank_i,
  input logic          active_i,
  input logic          vbl_quiet_i,
  input logic [DW-1:0] y_i,
  input logic [DW-1:0] cb_i,
  input logic [DW-1:0] cr_i,
  input logic [DW-1:0] y_o,
  input logic [DW-1:0] cb_o,
  input logic [DW-1:0] cr_o
);
  logic rst_seen_q = 1'b0;
  logic ins_y, ins_c, any_sync, quiet_vid;

  assign ins_y     = (mode_i == 2'b01) || (mode_i == 2'b10);
  assign ins_c     = (mode_i == 2'b10);
  assign any_sync  = sync_lo_i || sync_hi_i;
  assign quiet_vid = active_i && !any_sync && !blank_i;

  always @(posedge clk_i) rst_seen_q <= !rst_ni;

  // R1
  always @(posedge clk_i)
    if (rst_seen_q && !rst_ni)
      assert_reset_zero_R1: assert (y_o == '0 && cb_o == '0 && cr_o == '0);

  assert_lo_luma_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_lo_i && ins_y |=> y_o == $past(y_sync_lo_i));

  assert_lo_chroma_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_lo_i && ins_c |=> cb_o == $past(c_sync_lo_i) && cr_o == $past(c_sync_lo_i));

  assert_hi_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_lo_i && sync_hi_i && ins_c |=>
      y_o == $past(y_sync_hi_i) && cb_o == $past(c_sync_hi_i) && cr_o == $past(c_sync_hi_i));

  assert_noins_chroma_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_sync && !ins_c |=> cb_o == $past(c_blank_i) && cr_o == $past(c_blank_i));

  assert_noins_luma_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_sync && !ins_y |=> y_o == $past(y_blank_i));

  assert_blank_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i && !any_sync |=>
      y_o == $past(y_blank_i) && cb_o == $past(c_blank_i) && cr_o == $past(c_blank_i));

  assert_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet_vid && !vbl_quiet_i |=>
      y_o == $past(y_i) && cb_o == $past(cb_i) && cr_o == $past(cr_i));

  assert_vbl_blank_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet_vid && vbl_quiet_i && !pass_vblank_i |=>
      y_o == $past(y_blank_i) && cb_o == $past(c_blank_i) && cr_o == $past(c_blank_i));

  assert_vbl_pass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet_vid && vbl_quiet_i && pass_vblank_i |=> y_o == $past(y_i));

  assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_sync && !blank_i && !active_i |=> y_o == $past(y_blank_i));
endmodule

bind csync_mux csync_mux_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .pass_vblank_i(pass_vblank_i),
  .y_sync_lo_i(y_sync_lo_i), .y_sync_hi_i(y_sync_hi_i), .y_blank_i(y_blank_i),
  .c_sync_lo_i(c_sync_lo_i), .c_sync_hi_i(c_sync_hi_i), .c_blank_i(c_blank_i),
  .sync_lo_i(sync_lo_i), .sync_hi_i(sync_hi_i), .blank_i(blank_i),
  .active_i(active_i), .vbl_quiet_i(vbl_quiet_i),
  .y_i(y_i), .cb_i(cb_i), .cr_i(cr_i), .y_o(y_o), .cb_o(cb_o), .cr_o(cr_o)
);

// File: tb/tb_csync_mux.sv
module tb_csync_mux;
  localparam int unsigned DW = 10;
  localparam logic [DW-1:0] YL = 10'h040, YH = 10'h3C0, YB = 10'h100;
  localparam logic [DW-1:0] CL = 10'h080, CH = 10'h380, CB = 10'h200;
  localparam logic [DW-1:0] DY = 10'h2AA, DB = 10'h155, DR = 10'h0F0;

  typedef struct packed {
    logic [1:0]    mode;
    logic          pass;
    logic [4:0]    fl;   // {sync_lo, sync_hi, blank, active, vbl_quiet}
    logic [3:0]    req;
    logic [DW-1:0] ey, ecb, ecr;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{2'b10, 1'b0, 5'b10000, 4'd3, YL, CL, CL},  // R3 all
    '{2'b01, 1'b0, 5'b10000, 4'd3, YL, CB, CB},  // R3 luma only
    '{2'b00, 1'b0, 5'b10000, 4'd5, YB, CB, CB},  // R5 none
    '{2'b11, 1'b0, 5'b10000, 4'd5, YB, CB, CB},  // R5 reserved
    '{2'b10, 1'b0, 5'b01000, 4'd4, YH, CH, CH},  // R4 all
    '{2'b01, 1'b0, 5'b01000, 4'd4, YH, CB, CB},  // R4 luma only
    '{2'b10, 1'b1, 5'b11111, 4'd3, YL, CL, CL},  // R3 priority
    '{2'b10, 1'b1, 5'b01110, 4'd4, YH, CH, CH},  // R4 over blank
    '{2'b10, 1'b1, 5'b00110, 4'd6, YB, CB, CB},  // R6
    '{2'b10, 1'b0, 5'b00010, 4'd7, DY, DB, DR},  // R7
    '{2'b00, 1'b0, 5'b00010, 4'd7, DY, DB, DR},  // R7 mode none
    '{2'b10, 1'b0, 5'b00011, 4'd8, YB, CB, CB},  // R8 blanked
    '{2'b10, 1'b1, 5'b00011, 4'd8, DY, DB, DR},  // R8 passed
    '{2'b01, 1'b1, 5'b00000, 4'd9, YB, CB, CB},  // R9
    '{2'b10, 1'b0, 5'b00001, 4'd9, YB, CB, CB}   // R9 quiet but not active
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic pass_vblank_i = 1'b0;
  logic sync_lo_i = 1'b0, sync_hi_i = 1'b0, blank_i = 1'b0, active_i = 1'b0, vbl_quiet_i = 1'b0;
  logic [DW-1:0] y_i = DY, cb_i = DB, cr_i = DR;
  logic [DW-1:0] y_o, cb_o, cr_o;
  int n_chk = 0, n_fail = 0;

  always #4 clk_i = ~clk_i;

  csync_mux #(.DW(DW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .pass_vblank_i(pass_vblank_i),
    .y_sync_lo_i(YL), .y_sync_hi_i(YH), .y_blank_i(YB),
    .c_sync_lo_i(CL), .c_sync_hi_i(CH), .c_blank_i(CB),
    .sync_lo_i(sync_lo_i), .sync_hi_i(sync_hi_i), .blank_i(blank_i),
    .active_i(active_i), .vbl_quiet_i(vbl_quiet_i),
    .y_i(y_i), .cb_i(cb_i), .cr_i(cr_i), .y_o(y_o), .cb_o(cb_o), .cr_o(cr_o)
  );

  task automatic chk(input string tag, input logic [DW-1:0] ey, ecb, ecr);
    n_chk++;
    if (y_o !== ey || cb_o !== ecb || cr_o !== ecr) begin
      n_fail++;
      $display("FAIL %s: got y=%h cb=%h cr=%h expected y=%h cb=%h cr=%h",
               tag, y_o, cb_o, cr_o, ey, ecb, ecr);
    end
  endtask

  task automatic set_flags(input logic [4:0] fl);
    {sync_lo_i, sync_hi_i, blank_i, active_i, vbl_quiet_i} = fl;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1: outputs zero in reset despite stimulus
    mode_i = 2'b10; set_flags(5'b10000);
    repeat (3) @(negedge clk_i);
    chk("R1 reset", '0, '0, '0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      mode_i = VEC[i].mode; pass_vblank_i = VEC[i].pass; set_flags(VEC[i].fl);
      @(negedge clk_i);
      chk($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].ey, VEC[i].ecb, VEC[i].ecr);
    end

    // R7: a second data pattern
    @(negedge clk_i);
    mode_i = 2'b01; set_flags(5'b00010); y_i = 10'h3FF; cb_i = 10'h001; cr_i = 10'h200;
    @(negedge clk_i);
    chk("R7 data2", 10'h3FF, 10'h001, 10'h200);

    // R2: exact one-cycle latency
    mode_i = 2'b10; set_flags(5'b10000);
    #1 chk("R2 before edge", 10'h3FF, 10'h001, 10'h200);
    @(posedge clk_i); #2;
    chk("R2 after edge", YL, CL, CL);

    // R1: asynchronous clear mid-cycle
    @(negedge clk_i);
    #1 rst_ni = 1'b0;
    #1 chk("R1 async", '0, '0, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R3 after reset", YL, CL, CL);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule